// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block fronts a small byte-addressable nonvolatile data store, modelled here as an internal byte array whose writes take a fixed number of clock cycles. Software on the host side sees four byte-wide registers: an address, a data byte, a control byte and a key register that can only be written. Reads complete in one cycle. A write runs for a parameterised latency, and software polls the start bit until it clears.

Accidental writes are hard to make. After reset, write enable is off and a hold-off window blocks every write. A write starts only if write enable is already set, the two key bytes have just been written in the right order, and the window has expired. A second access path, intended for debug or programming equipment, reads and writes the array directly. It is shut off by a code-protect input. The host-side registers are not affected by code protect.

Top module: `nvw_guard_ctrl`

## Requirements
- R1: After reset, the address register, data register, write enable, busy and error flag are all 0.
- R2: For HOLD_CYCLES clock edges after reset release, no write to the array starts. A host start attempt in this window sets the error flag and leaves busy at 0. External writes in this window are dropped.
- R3: A host start is accepted only if the last two host writes were 0x55 and then 0xAA to the key register (select 3). A wrong byte, a reversed order, or any write to another register between the two bytes cancels the sequence.
- R4: The control register is select 2. Bit 0 requests a read, bit 1 requests a write start, bit 2 is write enable, and writing 1 to bit 3 clears the error flag. A start request made while write enable is 0 has no effect, except that it sets the error flag, which stays set until cleared.
- R5: An accepted start raises busy for exactly WR_LAT cycles. When busy falls, the array byte at the address register holds the data register value.
- R6: While busy is 1, host writes to the address register (select 0) and data register (select 1) are ignored. Further start and read requests are also ignored, and they do not set the error flag.
- R7: Every write consumes its key sequence. A second start without new key bytes is refused and sets the error flag.
- R8: A read request (bit 0 set, bit 1 clear) loads the data register with the array byte at the current address on that same edge.
- R9: With code_protect at 1, an external read returns 0x00 on ext_rdata in the next cycle, and an external write leaves the array unchanged.
- R10: With code_protect at 0, an external read returns the array byte in the next cycle, and an external write updates the array on that edge. Host reads and writes work the same whether code_protect is 0 or 1.
- R11: An external write made while busy is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | Host register write strobe |
| cpu_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| cpu_wdata | input | 8 | Host write byte |
| addr_q | output | AW | Address register |
| data_q | output | 8 | Data register |
| wren | output | 1 | Write enable bit |
| busy | output | 1 | Write start bit, held until the write completes |
| err | output | 1 | Sticky refused-start flag |
| code_protect | input | 1 | Shuts off the external port when 1 |
| ext_we | input | 1 | External write strobe |
| ext_re | input | 1 | External read strobe |
| ext_addr | input | AW | External address |
| ext_wdata | input | 8 | External write byte |
| ext_rdata | output | 8 | External read byte, registered |

## Verification
The bench builds the block with AW=4, WR_LAT=5 and HOLD_CYCLES=20. A 16-byte array is small enough to preload completely through the external port, so every later read can be predicted exactly. With a latency of 5 cycles there is room to inject address, data, start and external writes while a write is still in flight. The 20-cycle hold-off lets a complete enable, key and start sequence land inside the window. Seeded random writes (some with the correct key, some with the enable or key deliberately broken), host reads and external accesses under random code protect then run against the bench's own model of the array.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR   = 2'd0,
      SEL_DATA   = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_UNLOCK = 2'd3
   } nvw_sel_e;

   localparam int CTL_RD  = 0;
   localparam int CTL_WR  = 1;
   localparam int CTL_EN  = 2;
   localparam int CTL_CLR = 3;

   typedef enum logic [1:0] {
      KEY_IDLE  = 2'd0,
      KEY_HALF  = 2'd1,
      KEY_ARMED = 2'd2
   } nvw_key_e;
endpackage

// File: rtl/nvw_unlock.sv
module nvw_unlock #(
   parameter logic [7:0] KEY_A = 8'h55,
   parameter logic [7:0] KEY_B = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_key,
   input  logic       wr_other,
   input  logic [7:0] key_byte,
   output logic       armed
);
   import nvw_pkg::*;

   nvw_key_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_other) begin
         state_d = KEY_IDLE;
      end else if (wr_key) begin
         if (key_byte == KEY_A)                            state_d = KEY_HALF;
         else if (key_byte == KEY_B && state_q == KEY_HALF) state_d = KEY_ARMED;
         else                                              state_d = KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KEY_IDLE;
      else        state_q <= state_d;
   end

   assign armed = (state_q == KEY_ARMED);

   // R3
   key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(wr_key && key_byte == KEY_B));
endmodule

// File: rtl/nvw_holdoff.sv
module nvw_holdoff #(
   parameter int HOLD_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   generate
      if (HOLD_CYCLES == 0) begin : g_none
         assign done = 1'b1;
      end else begin : g_count
         localparam int HW = $clog2(HOLD_CYCLES + 1);
         logic [HW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_q <= HW'(HOLD_CYCLES);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign done = (cnt_q == '0);
      end
   endgenerate

   // R2
   hold_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> done);
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/nvw_guard_ctrl.sv
module nvw_guard_ctrl #(
   parameter int         AW          = 6,
   parameter int         WR_LAT      = 8,
   parameter int         HOLD_CYCLES = 64,
   parameter logic [7:0] KEY_A       = 8'h55,
   parameter logic [7:0] KEY_B       = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [1:0]    cpu_sel,
   input  logic [7:0]    cpu_wdata,
   output logic [AW-1:0] addr_q,
   output logic [7:0]    data_q,
   output logic          wren,
   output logic          busy,
   output logic          err,
   input  logic          code_protect,
   input  logic          ext_we,
   input  logic          ext_re,
   input  logic [AW-1:0] ext_addr,
   input  logic [7:0]    ext_wdata,
   output logic [7:0]    ext_rdata
);
   import nvw_pkg::*;

   localparam int DW = 8;
   localparam int CW = $clog2(WR_LAT + 1);

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("nvw_guard_ctrl: AW must be 1..8");
      end
      if (WR_LAT < 1) begin : g_bad_lat
         $error("nvw_guard_ctrl: WR_LAT must be at least 1");
      end
      if (HOLD_CYCLES < 0) begin : g_bad_hold
         $error("nvw_guard_ctrl: HOLD_CYCLES must not be negative");
      end
   endgenerate

   nvw_sel_e sel;
   logic wr_addr, wr_data, wr_ctrl, wr_key;
   logic armed, hold_done;
   logic start_req, start_ok, start_bad, read_req, wr_done, ext_wr_ok;
   logic [CW-1:0] lat_cnt;
   logic [DW-1:0] rd_int, rd_ext;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [DW-1:0] mem_wdata;

   assign sel     = nvw_sel_e'(cpu_sel);
   assign wr_addr = cpu_we && sel == SEL_ADDR;
   assign wr_data = cpu_we && sel == SEL_DATA;
   assign wr_ctrl = cpu_we && sel == SEL_CTRL;
   assign wr_key  = cpu_we && sel == SEL_UNLOCK;

   nvw_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk(clk), .rst_n(rst_n), .wr_key(wr_key),
      .wr_other(cpu_we && !wr_key), .key_byte(cpu_wdata), .armed(armed)
   );

   nvw_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .done(hold_done)
   );

   assign start_req = wr_ctrl && cpu_wdata[CTL_WR] && !busy;
   assign start_ok  = start_req && wren && armed && hold_done;
   assign start_bad = start_req && !start_ok;
   assign read_req  = wr_ctrl && cpu_wdata[CTL_RD] && !cpu_wdata[CTL_WR] && !busy;
   assign wr_done   = busy && lat_cnt == CW'(1);
   assign ext_wr_ok = ext_we && !code_protect && hold_done && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         wren    <= 1'b0;
         busy    <= 1'b0;
         err     <= 1'b0;
         lat_cnt <= '0;
      end else begin
         if (wr_addr && !busy) addr_q <= cpu_wdata[AW-1:0];
         if (wr_data && !busy) data_q <= cpu_wdata;
         else if (read_req)    data_q <= rd_int;
         if (wr_ctrl) wren <= cpu_wdata[CTL_EN];
         if (start_bad)                         err <= 1'b1;
         else if (wr_ctrl && cpu_wdata[CTL_CLR]) err <= 1'b0;
         if (start_ok) begin
            busy    <= 1'b1;
            lat_cnt <= CW'(WR_LAT);
         end else if (busy) begin
            lat_cnt <= lat_cnt - 1'b1;
            if (lat_cnt == CW'(1)) busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ext_rdata <= '0;
      else if (ext_re) ext_rdata <= code_protect ? '0 : rd_ext;
   end

   assign mem_we    = wr_done || ext_wr_ok;
   assign mem_waddr = wr_done ? addr_q : ext_addr;
   assign mem_wdata = wr_done ? data_q : ext_wdata;

   nvw_array #(.AW(AW), .DW(DW)) u_arr (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr_a(addr_q), .rdata_a(rd_int),
      .raddr_b(ext_addr), .rdata_b(rd_ext)
   );

   // R2
   no_start_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hold_done));
   // R4
   start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wren) && $past(armed));
   // R7
   key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !armed);
   // R6
   frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) && busy |-> $stable(addr_q) && $stable(data_q));
   // R9
   protected_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ext_re && code_protect) |-> ext_rdata == 8'h00);
endmodule

// File: tb/tb_nvw_guard_ctrl.sv
module tb_nvw_guard_ctrl;
   localparam int AW = 4;
   localparam int LAT = 5;
   localparam int HOLD = 20;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_we = 1'b0;
   logic [1:0] cpu_sel = '0;
   logic [7:0] cpu_wdata = '0;
   logic [AW-1:0] addr_q;
   logic [7:0] data_q, ext_rdata;
   logic wren, busy, err;
   logic code_protect = 1'b0, ext_we = 1'b0, ext_re = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [7:0] ext_wdata = '0;

   int checks = 0;
   int fails = 0;
   logic [7:0] mem_m [DEPTH];

   always #4 clk = ~clk;

   nvw_guard_ctrl #(.AW(AW), .WR_LAT(LAT), .HOLD_CYCLES(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
      .cpu_wdata(cpu_wdata), .addr_q(addr_q), .data_q(data_q), .wren(wren),
      .busy(busy), .err(err), .code_protect(code_protect), .ext_we(ext_we),
      .ext_re(ext_re), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

   function automatic logic [7:0] exp_ext(input logic cp, input int a);
      return cp ? 8'h00 : mem_m[a];
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [1:0] s, input logic [7:0] v);
      cpu_we = 1'b1; cpu_sel = s; cpu_wdata = v;
      @(posedge clk); #1 cpu_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic ext_op(input logic w, input logic r, input int a,
                         input logic [7:0] v, input logic cp);
      ext_we = w; ext_re = r; ext_addr = AW'(a); ext_wdata = v; code_protect = cp;
      @(posedge clk); #1 ext_we = 1'b0; ext_re = 1'b0;
      @(negedge clk);
   endtask

   task automatic key_ok();
      cpu_wr(2'd3, 8'h55);
      cpu_wr(2'd3, 8'hAA);
   endtask

   task automatic wait_busy(input string tag);
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(tag, n, LAT);
   endtask

   task automatic host_read(input int a, input string tag);
      cpu_wr(2'd0, 8'(a));
      cpu_wr(2'd2, 8'h05);
      chk(tag, data_q, mem_m[a]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog expired actual=0 expected=1");
      fails++;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 addr", addr_q, 0); chk("R1 data", data_q, 0);
      chk("R1 wren", wren, 0); chk("R1 busy", busy, 0); chk("R1 err", err, 0);
      // R2 start attempt inside hold-off window
      cpu_wr(2'd2, 8'h04); key_ok(); cpu_wr(2'd2, 8'h06);
      chk("R2 busy in window", busy, 0); chk("R2 err in window", err, 1);
      cpu_wr(2'd2, 8'h0C);
      chk("R4 err cleared", err, 0);
      repeat (HOLD + 2) @(negedge clk);
      // preload through external port
      for (int i = 0; i < DEPTH; i++) begin
         mem_m[i] = 8'(i * 7 + 3);
         ext_op(1'b1, 1'b0, i, mem_m[i], 1'b0);
      end
      ext_op(1'b0, 1'b1, 9, 8'h00, 1'b0);
      chk("R10 ext read", ext_rdata, exp_ext(1'b0, 9));
      // R5 good write
      cpu_wr(2'd0, 8'd3); cpu_wr(2'd1, 8'hA5); key_ok(); cpu_wr(2'd2, 8'h06);
      chk("R5 busy set", busy, 1);
      wait_busy("R5 busy length");
      mem_m[3] = 8'hA5;
      ext_op(1'b0, 1'b1, 3, 8'h00, 1'b0);
      chk("R5 array written", ext_rdata, 8'hA5);
      // R7 reuse of consumed key
      cpu_wr(2'd2, 8'h06);
      chk("R7 no busy", busy, 0); chk("R7 err", err, 1);
      cpu_wr(2'd2, 8'h0C);
      // R3 reversed order
      cpu_wr(2'd3, 8'hAA); cpu_wr(2'd3, 8'h55); cpu_wr(2'd2, 8'h06);
      chk("R3 reversed busy", busy, 0); chk("R3 reversed err", err, 1);
      cpu_wr(2'd2, 8'h0C);
      // R3 wrong byte between
      cpu_wr(2'd3, 8'h55); cpu_wr(2'd3, 8'h12); cpu_wr(2'd3, 8'hAA); cpu_wr(2'd2, 8'h06);
      chk("R3 wrong byte err", err, 1);
      cpu_wr(2'd2, 8'h0C);
      // R3 other register written between keys
      cpu_wr(2'd3, 8'h55); cpu_wr(2'd0, 8'd3); cpu_wr(2'd3, 8'hAA); cpu_wr(2'd2, 8'h06);
      chk("R3 interleaved busy", busy, 0); chk("R3 interleaved err", err, 1);
      // R4 without write enable
      cpu_wr(2'd2, 8'h08); key_ok(); cpu_wr(2'd2, 8'h02);
      chk("R4 no enable busy", busy, 0); chk("R4 sticky err", err, 1);
      cpu_wr(2'd0, 8'd1);
      chk("R4 err still set", err, 1);
      cpu_wr(2'd2, 8'h0C);
      // R6 and R11 during busy
      cpu_wr(2'd0, 8'd5); cpu_wr(2'd1, 8'h3C); key_ok(); cpu_wr(2'd2, 8'h06);
      cpu_wr(2'd0, 8'd9); cpu_wr(2'd1, 8'h11); cpu_wr(2'd2, 8'h07);
      ext_op(1'b1, 1'b0, 6, 8'hEE, 1'b0);
      chk("R6 addr frozen", addr_q, 5); chk("R6 data frozen", data_q, 8'h3C);
      chk("R6 no err", err, 0);
      while (busy) @(negedge clk);
      mem_m[5] = 8'h3C;
      ext_op(1'b0, 1'b1, 5, 8'h00, 1'b0);
      chk("R6 written value", ext_rdata, 8'h3C);
      ext_op(1'b0, 1'b1, 6, 8'h00, 1'b0);
      chk("R11 ext write dropped", ext_rdata, mem_m[6]);
      // R8 host read
      host_read(9, "R8 host read");
      // R9 protected port
      ext_op(1'b0, 1'b1, 9, 8'h00, 1'b1);
      chk("R9 protected read", ext_rdata, 8'h00);
      ext_op(1'b1, 1'b0, 9, 8'h99, 1'b1);
      host_read(9, "R9 write dropped");
      // R10 host access under protection
      cpu_wr(2'd0, 8'd2); cpu_wr(2'd1, 8'h6B); key_ok(); cpu_wr(2'd2, 8'h06);
      wait_busy("R10 protected host write");
      mem_m[2] = 8'h6B;
      host_read(2, "R10 host read under protect");
      code_protect = 1'b0;
      // random phase
      for (int it = 0; it < 150; it++) begin
         int op, a;
         logic cp;
         logic [7:0] v;
         op = $urandom_range(0, 3); a = $urandom_range(0, DEPTH - 1);
         v = 8'($urandom); cp = 1'($urandom);
         case (op)
            0: begin
               int kind = $urandom_range(0, 3);
               cpu_wr(2'd2, kind == 1 ? 8'h08 : 8'h0C);
               cpu_wr(2'd0, 8'(a)); cpu_wr(2'd1, v);
               if (kind == 2) begin cpu_wr(2'd3, 8'h55); cpu_wr(2'd3, 8'h5A); end
               else if (kind == 3) begin cpu_wr(2'd3, 8'h55); cpu_wr(2'd1, v); cpu_wr(2'd3, 8'hAA); end
               else key_ok();
               cpu_wr(2'd2, kind == 1 ? 8'h02 : 8'h06);
               if (kind == 0) begin
                  wait_busy("R5 random write");
                  mem_m[a] = v;
               end else begin
                  chk("R3 random refused", busy, 0);
                  chk("R4 random err", err, 1);
               end
            end
            1: host_read(a, "R8 random read");
            2: begin
               ext_op(1'b1, 1'b0, a, v, cp);
               if (!cp) mem_m[a] = v;
            end
            default: begin
               ext_op(1'b0, 1'b1, a, 8'h00, cp);
               chk(cp ? "R9 random ext read" : "R10 random ext read", ext_rdata, exp_ext(cp, a));
            end
         endcase
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule